// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

This block converts a parallel word into a serial bit stream. It is a chain of stages. On a rising clock edge that is not blocked, the chain does one of two things. It can capture the whole parallel word. It can also move every stage one place toward the far end, with a fresh bit entering at the near end from the serial input. Only the far-end stage drives the serial output. All stages are also brought out on a read-only port so that neighbouring logic can observe them.

A hold input freezes the entire chain across clock edges. This lets the system clock run freely while the stream is paused on command. The hold is built as a synchronous clock enable on the design clock, not as a gated clock net. An active-low clear empties every stage at once, without waiting for a clock edge, and takes precedence over every other input. The word width is a parameter, with a default of eight stages.

Top module: `plsr_core`

## Requirements
- R1: While `clr_n` is low, every stage and `ser_o` read 0 at once, without waiting for a clock edge and regardless of the mode, hold, serial and parallel inputs.
- R2: On a rising edge with `clr_n` high, `hold_i` low and `shift_sel_i` high, stage 0 takes `ser_i` and each stage k>0 takes the previous value of stage k-1.
- R3: On a rising edge with `clr_n` high, `hold_i` low and `shift_sel_i` low, stage k takes `par_i[k]`. Lowering `shift_sel_i` or changing `par_i` between edges leaves the stages unchanged until that edge.
- R4: During a parallel load the value of `ser_i` has no effect on any stage.
- R5: On any rising edge with `hold_i` high, all stages keep their values, in both shift and load mode.
- R6: `ser_o` always equals the last stage (index WIDTH-1). After a load, it presents `par_i[WIDTH-1]` down to `par_i[0]`, one bit per shift, and then the serial-input bits in the order they were shifted in.
- R7: `stage_o[k]` shows stage k, where stage 0 is the stage fed by `ser_i` and stage WIDTH-1 is the one that drives `ser_o`.
- R8: A clear asserted in the middle of a shift stream discards the stream. Shifting after the clear is released starts again from an all-zero chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Design clock; stages update on the rising edge |
| clr_n | input | 1 | Asynchronous active-low clear of all stages |
| hold_i | input | 1 | High blocks every clock edge from reaching the stages |
| shift_sel_i | input | 1 | High selects shifting, low selects parallel load |
| ser_i | input | 1 | Serial bit entering stage 0 when shifting |
| par_i | input | WIDTH | Parallel word; bit k goes to stage k on a load |
| ser_o | output | 1 | Serial output, the last stage |
| stage_o | output | WIDTH | All stage values, bit k is stage k |

## Verification
On every clock edge, assertions check the single-step rules. A blocked edge leaves the stages unchanged. An enabled shift moves the serial bit into stage 0 and the next-to-last stage into the output. An enabled load captures the parallel word whatever the serial input is. A low clear forces an all-zero chain. Other properties can be shown only by the bench's scenarios. One is the full order of output bits across a load and a run of eight or more shifts. Another is that stages stay still between edges after the mode or data change. A third is that a clear arriving mid-stream takes effect before any edge and leaves no trace of the stream once shifting resumes.

// File: rtl/plsr_pkg.sv
package plsr_pkg;

  // What a rising clock edge does to the chain.
  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_SHIFT = 2'd1,
    STEP_LOAD  = 2'd2
  } step_e;

  // Hold beats mode; mode then picks shift or load.
  function automatic step_e decode_step(input logic hold, input logic shift_sel);
    if (hold)           return STEP_HOLD;
    else if (shift_sel) return STEP_SHIFT;
    else                return STEP_LOAD;
  endfunction

  // Next value of one stage for a given step.
  function automatic logic next_bit(input step_e step, input logic cur,
                                    input logic chain_in, input logic par_in);
    case (step)
      STEP_SHIFT: return chain_in;
      STEP_LOAD:  return par_in;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/plsr_ctrl.sv
module plsr_ctrl
  import plsr_pkg::*;
(
  input  logic  hold_i,
  input  logic  shift_sel_i,
  output step_e step_o,
  output logic  adv_o,
  output logic  do_shift_o,
  output logic  do_load_o
);

  step_e step;

  always_comb begin
    step = decode_step(hold_i, shift_sel_i);
  end

  assign step_o     = step;
  assign adv_o      = (step != STEP_HOLD);
  assign do_shift_o = (step == STEP_SHIFT);
  assign do_load_o  = (step == STEP_LOAD);

endmodule

// File: rtl/plsr_cell.sv
module plsr_cell
  import plsr_pkg::*;
(
  input  logic  clk,
  input  logic  clr_n,
  input  step_e step_i,
  input  logic  chain_bit_i,
  input  logic  par_bit_i,
  output logic  q_o
);

  logic q_q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q_q <= 1'b0;
    else        q_q <= next_bit(step_i, q_q, chain_bit_i, par_bit_i);
  end

  assign q_o = q_q;

endmodule

// File: rtl/plsr_core.sv
module plsr_core
  import plsr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             hold_i,
  input  logic             shift_sel_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic             ser_o,
  output logic [WIDTH-1:0] stage_o
);

  localparam int LAST = WIDTH - 1;

  step_e            step;
  logic             do_adv;
  logic             do_shift;
  logic             do_load;
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] chain;

  plsr_ctrl u_ctrl (
    .hold_i      (hold_i),
    .shift_sel_i (shift_sel_i),
    .step_o      (step),
    .adv_o       (do_adv),
    .do_shift_o  (do_shift),
    .do_load_o   (do_load)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign chain[i] = ser_i;
    end else begin : g_body
      assign chain[i] = stage_q[i-1];
    end

    plsr_cell u_cell (
      .clk         (clk),
      .clr_n       (clr_n),
      .step_i      (step),
      .chain_bit_i (chain[i]),
      .par_bit_i   (par_i[i]),
      .q_o         (stage_q[i])
    );
  end

  assign ser_o   = stage_q[LAST];
  assign stage_o = stage_q;

  // R1
  clr_zero_chk: assert property (@(posedge clk)
    !clr_n |-> (stage_o == '0) && !ser_o);

  // R2
  shift_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
    do_shift |=> (stage_o[0] == $past(ser_i)) && (ser_o == $past(stage_o[LAST-1])));

  // R3 R4
  load_take_chk: assert property (@(posedge clk) disable iff (!clr_n)
    do_load |=> (stage_o == $past(par_i)));

  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (hold_i && !do_adv) |=> $stable(stage_o));

endmodule

// File: tb/plsr_core_bench.sv
module plsr_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clr_n;
  logic         hold_i;
  logic         shift_sel_i;
  logic         ser_i;
  logic [W-1:0] par_i;
  logic         ser_o;
  logic [W-1:0] stage_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [W-1:0] ref_q;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic [W-1:0] mon_e;
  string        mon_t;

  always #(CLK_PERIOD/2) clk = ~clk;

  plsr_core #(.WIDTH(W)) u_plsr_core (
    .clk         (clk),
    .clr_n       (clr_n),
    .hold_i      (hold_i),
    .shift_sel_i (shift_sel_i),
    .ser_i       (ser_i),
    .par_i       (par_i),
    .ser_o       (ser_o),
    .stage_o     (stage_o)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected state.
  task automatic cycle(input bit sel, input bit inh, input bit s,
                       input logic [W-1:0] p, input string req);
    @(negedge clk);
    shift_sel_i = sel; hold_i = inh; ser_i = s; par_i = p;
    #1 check({req, " (no change before edge, R3)"}, stage_o, ref_q);
    if (!inh) begin
      if (sel) begin
        for (int k = W-1; k > 0; k--) ref_q[k] = ref_q[k-1];
        ref_q[0] = s;
      end else begin
        ref_q = p;
      end
    end
    exp_q.push_back(ref_q);
    tag_q.push_back(req);
  endtask

  task automatic clear_pulse(input string req);
    @(negedge clk);
    clr_n = 1'b0; hold_i = 1'b0; shift_sel_i = 1'b1; ser_i = 1'b1; par_i = '1;
    #1;
    check({req, " immediate clear R1"}, stage_o, '0);
    check({req, " immediate clear out R1"}, {{(W-1){1'b0}}, ser_o}, '0);
    ref_q = '0;
    exp_q.push_back(ref_q); tag_q.push_back({req, " R1"});
    @(negedge clk);
    clr_n = 1'b1; hold_i = 1'b1;
    exp_q.push_back(ref_q); tag_q.push_back({req, " R5"});
  endtask

  task automatic settle();
    @(posedge clk);
    #(CLK_PERIOD/4 + 1);
  endtask

  // Monitor: pops one expected item after each edge that has one.
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      mon_t = tag_q.pop_front();
      check(mon_t, stage_o, mon_e);
      check({mon_t, " out R6"}, {{(W-1){1'b0}}, ser_o}, {{(W-1){1'b0}}, mon_e[W-1]});
    end
  end

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pat;
    logic [W-1:0] sbits;
    clr_n = 1'b0; hold_i = 1'b1; shift_sel_i = 1'b0; ser_i = 1'b0; par_i = '0;
    ref_q = '0;
    #2 check("R1 reset state", stage_o, '0);
    repeat (2) @(negedge clk);
    clr_n = 1'b1;
    settle();
    check("R1 after release with hold", stage_o, '0);

    // R3 load, R5 hold in both modes
    cycle(1'b0, 1'b0, 1'b0, 8'hA5, "R3 load");
    cycle(1'b0, 1'b1, 1'b0, 8'h3C, "R5 hold in load mode");
    cycle(1'b1, 1'b1, 1'b1, 8'h3C, "R5 hold in shift mode");
    // R4 serial ignored during load
    cycle(1'b0, 1'b0, 1'b1, 8'h5A, "R4 load ser=1");
    cycle(1'b0, 1'b0, 1'b0, 8'h5A, "R4 load ser=0");
    settle();
    check("R4 serial ignored", stage_o, 8'h5A);

    // R7 stage ordering
    cycle(1'b0, 1'b0, 1'b0, 8'h01, "R7 load stage0");
    cycle(1'b1, 1'b0, 1'b0, 8'h00, "R7 shift once");
    settle();
    check("R7 stage1 set", stage_o, 8'h02);

    // R6 output order after load
    pat   = 8'b1011_0010;
    sbits = 8'b0110_1001;
    cycle(1'b0, 1'b0, 1'b0, pat, "R6 load");
    settle();
    check("R6 first out is top bit", {{(W-1){1'b0}}, ser_o}, {{(W-1){1'b0}}, pat[W-1]});
    for (int k = 0; k < W + 3; k++) begin
      logic ebit;
      cycle(1'b1, 1'b0, sbits[k % W], 8'h00, "R6 shift out");
      settle();
      ebit = (k + 1 < W) ? pat[W-2-k] : sbits[k + 1 - W];
      check("R6 out order", {{(W-1){1'b0}}, ser_o}, {{(W-1){1'b0}}, ebit});
    end

    // R2/R5 stream with hold pulses
    for (int k = 0; k < 12; k++) begin
      cycle(1'b1, (k % 4) == 2, (k % 3) == 0, 8'hFF, ((k % 4) == 2) ? "R5 hold pulse" : "R2 shift");
    end

    // R8 clear mid-shift, then restart from zero
    cycle(1'b0, 1'b0, 1'b0, 8'hFF, "R3 load ones");
    cycle(1'b1, 1'b0, 1'b0, 8'h00, "R2 shift");
    clear_pulse("R8 mid-shift");
    cycle(1'b1, 1'b0, 1'b1, 8'hFF, "R8 resume");
    cycle(1'b1, 1'b0, 1'b0, 8'hFF, "R8 resume");
    settle();
    check("R8 only new bits", stage_o, 8'h02);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule